// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer capture/compare unit. It watches one of several shared free-running timer values, picked by a select input, and works in one of a set of behaviours chosen by a 4-bit mode register. In the capture behaviours it synchronizes an external input pin, detects edges on it, and latches the selected timer value on the chosen edge. An edge prescaler can reduce this to one capture per group of edges. In the compare behaviours it checks a 16-bit compare register against the selected timer value. On a match it can drive an output pin, raise an event flag, or send a one-cycle request to reset the timer.

Software programs the channel through a small write port. Address 0 writes the mode field from `wr_data[3:0]`. Address 1 writes the compare value. Each capture or compare event sets a sticky flag, and software clears it with `flag_clr`. The timer counters and any waveform generation are outside this block.

Top module: `ccu_channel`

## Requirements
- R1: While `rst` is high and on the first cycle after it drops, `flag`, `cap_val`, `pin_out` and `tmr_rst` are all 0, and the mode is disabled (code 0).
- R2: With mode code 0101, a rising edge on `pin_in` is captured. It passes through a 2-flop synchronizer, and the value of the selected timer at the third rising clock edge after the pin change is latched into `cap_val`. The flag is also set.
- R3: With mode code 0100, only falling edges of `pin_in` cause a capture. A rising edge leaves `cap_val` unchanged.
- R4: Mode code 0110 captures on every 4th synchronized rising edge, and code 0111 captures on every 16th. Any write to the mode field restarts the edge count from zero.
- R5: `tb_sel` picks the timer slice `tb_vals[16*tb_sel +: 16]`. That slice is the time base for both capture and compare. The other slices have no effect.
- R6: With mode code 0010, the pin level is inverted when the selected timer first equals the compare value, and the flag is set. A match that persists over several cycles acts only once. The next inversion needs the timer to leave the value and then return to it.
- R7: A write of mode code 1000 drives `pin_out` low on the next cycle, and a match then forces it high. A write of code 1001 drives it high, and a match forces it low. Both set the flag on a match.
- R8: With mode code 1010, a match only sets the flag. `pin_out` follows `gpio_in` combinationally.
- R9: With mode code 1011, a match sets the flag and raises `tmr_rst` for exactly one cycle. The pin level is left unchanged.
- R10: Codes 0000, 0001, 0011 and 11xx are disabled. No capture, no flag and no `tmr_rst` occur. `pin_out` is held low, and the edge prescaler is cleared.
- R11: `flag` stays set until a cycle with `flag_clr` high. If a new event and `flag_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode field, 1 = compare value |
| wr_data | input | 16 | Write data |
| tb_sel | input | 2 | Time-base select |
| tb_vals | input | 64 | Four packed 16-bit timer values, slice 0 in the low bits |
| pin_in | input | 1 | Asynchronous capture input |
| gpio_in | input | 1 | General I/O level passed to the pin in interrupt-only compare |
| pin_out | output | 1 | Channel output pin |
| cap_val | output | 16 | Last captured timer value |
| flag | output | 1 | Sticky event flag |
| flag_clr | input | 1 | Software clear of the flag |
| tmr_rst | output | 1 | One-cycle timer-reset request |

## Verification
The bench builds the channel with its defaults: 16-bit timers, four time bases, a 2-stage synchronizer and prescaler divisors of 4 and 16. With four time bases, every capture and compare test can be repeated for each `tb_sel` value. With the divisor of 16, the full prescaler cycle can be driven pulse by pulse and checked against a count kept in the bench. The disabled behaviour is swept over every code that does not name a function.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;

    typedef enum logic [3:0] {
        MD_OFF       = 4'b0000,
        MD_RSV_A     = 4'b0001,
        MD_TOGGLE    = 4'b0010,
        MD_RSV_B     = 4'b0011,
        MD_CAP_FALL  = 4'b0100,
        MD_CAP_RISE  = 4'b0101,
        MD_CAP_DIVLO = 4'b0110,
        MD_CAP_DIVHI = 4'b0111,
        MD_CMP_SET   = 4'b1000,
        MD_CMP_CLR   = 4'b1001,
        MD_CMP_IRQ   = 4'b1010,
        MD_CMP_TRIG  = 4'b1011
    } mode_e;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_CMP  = 1'b1;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic pin_we;
        logic pin_val;
        logic pulse;
    } cmp_act_t;

    function automatic logic mode_is_capture(logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic mode_is_compare(logic [3:0] m);
        return (m == MD_TOGGLE) || (m[3:2] == 2'b10);
    endfunction

    function automatic logic mode_is_off(logic [3:0] m);
        return !mode_is_capture(m) && !mode_is_compare(m);
    endfunction

    // Pin level right after a mode write.
    function automatic logic mode_init_pin(logic [3:0] m, logic cur);
        logic r;
        if (m == MD_CMP_SET)      r = 1'b0;
        else if (m == MD_CMP_CLR) r = 1'b1;
        else if (mode_is_off(m))  r = 1'b0;
        else                      r = cur;
        return r;
    endfunction

    // Effect of a compare match in a given mode.
    function automatic cmp_act_t compare_action(logic [3:0] m, logic cur);
        cmp_act_t a;
        a = '0;
        unique case (m)
            MD_TOGGLE:   begin a.pin_we = 1'b1; a.pin_val = ~cur; end
            MD_CMP_SET:  begin a.pin_we = 1'b1; a.pin_val = 1'b1; end
            MD_CMP_CLR:  begin a.pin_we = 1'b1; a.pin_val = 1'b0; end
            MD_CMP_TRIG: a.pulse = 1'b1;
            default:     a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ccu_edge_sync.sv
`timescale 1ns/1ps
module ccu_edge_sync
    import ccu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_in,
    output edge_t ev
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[LAST-1:0], pin_in};
    end

    // sh_q[LAST-1] is the synchronized level, sh_q[LAST] its previous sample
    always_comb begin
        ev.rise = sh_q[LAST-1] & ~sh_q[LAST];
        ev.fall = ~sh_q[LAST-1] & sh_q[LAST];
    end
endmodule

// File: rtl/ccu_prescale.sv
`timescale 1ns/1ps
module ccu_prescale
    import ccu_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic [3:0] mode,
    input  edge_t      ev,
    output logic       fire
);
    localparam int CW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          evt;

    always_comb begin
        evt      = 1'b0;
        last_cnt = '0;
        unique case (mode)
            MD_CAP_FALL:  evt = ev.fall;
            MD_CAP_RISE:  evt = ev.rise;
            MD_CAP_DIVLO: begin evt = ev.rise; last_cnt = CW'(DIV_LO - 1); end
            MD_CAP_DIVHI: begin evt = ev.rise; last_cnt = CW'(DIV_HI - 1); end
            default:      evt = 1'b0;
        endcase
        fire = evt && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || mode_is_off(mode)) cnt_q <= '0;
        else if (fire)                         cnt_q <= '0;
        else if (evt)                          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ccu_compare.sv
`timescale 1ns/1ps
module ccu_compare #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [TW-1:0] tv,
    input  logic [TW-1:0] cmp,
    output logic          match
);
    logic eq;
    logic eq_prev_q;

    assign eq    = (tv == cmp);
    assign match = active && eq && !eq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) eq_prev_q <= 1'b0;
        else     eq_prev_q <= active && eq;
    end
endmodule

// File: rtl/ccu_channel.sv
`timescale 1ns/1ps
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int TW          = 16,
    parameter int NUM_TB      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LO      = 4,
    parameter int DIV_HI      = 16,
    localparam int SELW       = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [TW-1:0]      wr_data,
    input  logic [SELW-1:0]    tb_sel,
    input  logic [NUM_TB*TW-1:0] tb_vals,
    input  logic               pin_in,
    input  logic               gpio_in,
    output logic               pin_out,
    output logic [TW-1:0]      cap_val,
    output logic               flag,
    input  logic               flag_clr,
    output logic               tmr_rst
);
    logic [3:0]    mode_q;
    logic [TW-1:0] cmp_q;
    logic          pin_q;
    logic [TW-1:0] tb_slice [NUM_TB];
    logic [TW-1:0] tv;
    logic          mode_wr;
    logic          cmp_wr;
    edge_t         ev;
    logic          cap_fire;
    logic          match;
    cmp_act_t      act;

    for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
        assign tb_slice[g] = tb_vals[g*TW +: TW];
    end

    assign tv      = tb_slice[tb_sel];
    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
    assign cmp_wr  = wr_en && (wr_addr == ADDR_CMP);

    ccu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .ev     (ev)
    );

    ccu_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (mode_wr),
        .mode  (mode_q),
        .ev    (ev),
        .fire  (cap_fire)
    );

    ccu_compare #(.TW(TW)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .active (mode_is_compare(mode_q)),
        .tv     (tv),
        .cmp    (cmp_q),
        .match  (match)
    );

    always_comb begin
        act = '0;
        if (match) act = compare_action(mode_q, pin_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_OFF;
            cmp_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= wr_data[3:0];
            if (cmp_wr)  cmp_q  <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       pin_q <= 1'b0;
        else if (mode_wr)              pin_q <= mode_init_pin(wr_data[3:0], pin_q);
        else if (mode_is_off(mode_q))  pin_q <= 1'b0;
        else if (act.pin_we)           pin_q <= act.pin_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
            flag    <= 1'b0;
            tmr_rst <= 1'b0;
        end else begin
            if (cap_fire) cap_val <= tv;
            flag    <= cap_fire | match | (flag & ~flag_clr);
            tmr_rst <= act.pulse;
        end
    end

    assign pin_out = (mode_q == MD_CMP_IRQ) ? gpio_in : pin_q;

endmodule

// File: rtl/ccu_channel_chk.sv
`timescale 1ns/1ps
module ccu_channel_chk
    import ccu_pkg::*;
#(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    mode_q,
    input logic          mode_wr,
    input logic          flag,
    input logic          flag_clr,
    input logic          tmr_rst,
    input logic          pin_out,
    input logic [TW-1:0] cap_val
);
    // R11: the flag only falls through a software clear
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        flag && !flag_clr |=> flag);

    // R9: the timer-reset request is a single-cycle pulse
    p_trig_single_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |=> !tmr_rst);

    // R9: the request only follows a cycle in the special-event mode
    p_trig_mode_r9: assert property (@(posedge clk) disable iff (rst)
        tmr_rst |-> $past(mode_q) == MD_CMP_TRIG);

    // R10: a disabled channel holds its pin low
    p_off_pin_r10: assert property (@(posedge clk) disable iff (rst)
        mode_is_off(mode_q) && !mode_wr |=> !pin_out);

    // R10: no capture outside the capture modes
    p_cap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !mode_is_capture(mode_q) |=> $stable(cap_val));

    // R1: reset clears the visible state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> !flag && !tmr_rst && (cap_val == '0));
endmodule

bind ccu_channel ccu_channel_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .mode_wr  (mode_wr),
    .flag     (flag),
    .flag_clr (flag_clr),
    .tmr_rst  (tmr_rst),
    .pin_out  (pin_out),
    .cap_val  (cap_val)
);

// File: tb/tb_ccu_channel.sv
`timescale 1ns/1ps
module tb_ccu_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  tb_sel = '0;
    logic [15:0] tvs [4];
    logic [63:0] tb_vals;
    logic        pin_in = 1'b0;
    logic        gpio_in = 1'b0;
    logic        pin_out;
    logic [15:0] cap_val;
    logic        flag;
    logic        flag_clr = 1'b0;
    logic        tmr_rst;

    int n_chk = 0;
    int n_bad = 0;
    int trig_cnt = 0;
    bit done = 0;

    localparam logic [15:0] CMP = 16'h4321;

    assign tb_vals = {tvs[3], tvs[2], tvs[1], tvs[0]};

    always #2.5 clk = ~clk;

    ccu_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tb_sel(tb_sel), .tb_vals(tb_vals), .pin_in(pin_in), .gpio_in(gpio_in),
        .pin_out(pin_out), .cap_val(cap_val), .flag(flag), .flag_clr(flag_clr),
        .tmr_rst(tmr_rst)
    );

    always @(negedge clk) if (!rst && tmr_rst) trig_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic pulse();
        pin_in = 1'b1; tick(4);
        pin_in = 1'b0; tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_cap;
        logic        pin_before;
        int          t0;
        logic [3:0]  off_codes [7];
        off_codes = '{4'h0, 4'h1, 4'h3, 4'hC, 4'hD, 4'hE, 4'hF};
        for (int i = 0; i < 4; i++) tvs[i] = 16'h0;

        tick(3);
        check("R1 flag in reset", flag, 0);
        check("R1 cap in reset", cap_val, 0);
        rst = 1'b0;
        tick(1);
        check("R1 flag", flag, 0);
        check("R1 cap_val", cap_val, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 tmr_rst", tmr_rst, 0);

        wr(1'b1, CMP);

        // R2 / R3 / R5: capture on each time base
        for (int s = 0; s < 4; s++) begin
            tb_sel = 2'(s);
            for (int i = 0; i < 4; i++) tvs[i] = 16'(16'h1111 * (i + 1) + s);
            wr(1'b0, 16'h5);
            clr_flag();
            pulse();
            check("R2 R5 rising capture value", cap_val, 16'(16'h1111 * (s + 1) + s));
            check("R11 flag after capture", flag, 1);
            wr(1'b0, 16'h4);
            exp_cap = cap_val;
            tvs[s] = 16'(16'h0F00 + s);
            pin_in = 1'b1; tick(4);
            check("R3 rising edge ignored", cap_val, exp_cap);
            pin_in = 1'b0; tick(4);
            check("R3 falling capture value", cap_val, 16'(16'h0F00 + s));
        end
        tb_sel = 2'd0;

        // R4: divide by 4 and by 16
        wr(1'b0, 16'h6);
        exp_cap = cap_val;
        for (int p = 1; p <= 8; p++) begin
            tvs[0] = 16'(p * 100);
            pulse();
            if (p % 4 == 0) exp_cap = 16'(p * 100);
            check("R4 every 4th rising", cap_val, exp_cap);
        end
        wr(1'b0, 16'h7);
        for (int p = 1; p <= 16; p++) begin
            tvs[0] = 16'(p * 37 + 5);
            pulse();
            if (p == 16) exp_cap = 16'(p * 37 + 5);
            check("R4 every 16th rising", cap_val, exp_cap);
        end
        // R4: rewriting the mode restarts the count
        wr(1'b0, 16'h6);
        tvs[0] = 16'h7001;
        pulse(); pulse();
        wr(1'b0, 16'h6);
        pulse(); pulse(); pulse();
        check("R4 count restarted by mode write", cap_val, exp_cap);
        pulse();
        check("R4 capture after restart", cap_val, 16'h7001);

        // R6: toggle on match
        tvs[0] = CMP - 5;
        wr(1'b0, 16'h0);
        wr(1'b0, 16'h2);
        check("R6 pin before match", pin_out, 0);
        clr_flag();
        tvs[0] = CMP; tick(1);
        check("R6 pin toggled", pin_out, 1);
        check("R6 flag on match", flag, 1);
        tick(3);
        check("R6 persistent match acts once", pin_out, 1);
        clr_flag();
        check("R11 cleared by software", flag, 0);
        tvs[0] = CMP + 1; tick(1);
        tvs[0] = CMP; tick(1);
        check("R6 second toggle", pin_out, 0);
        // R5: compare follows the selected slice
        tvs[0] = CMP + 1; tvs[2] = CMP - 1; tb_sel = 2'd2; tick(2);
        tvs[0] = CMP; tick(2);
        check("R5 unselected slice ignored", pin_out, 0);
        tvs[2] = CMP; tick(1);
        check("R5 selected slice matches", pin_out, 1);
        tb_sel = 2'd0; tvs[0] = CMP + 3; tick(2);

        // R7: set and clear from preset level
        wr(1'b0, 16'h8);
        check("R7 preset low", pin_out, 0);
        clr_flag();
        tvs[0] = CMP; tick(1);
        check("R7 forced high", pin_out, 1);
        check("R7 flag set", flag, 1);
        tvs[0] = CMP + 3; tick(1);
        wr(1'b0, 16'h9);
        check("R7 preset high", pin_out, 1);
        clr_flag();
        tvs[0] = CMP; tick(1);
        check("R7 forced low", pin_out, 0);
        check("R7 flag set", flag, 1);

        // R8: interrupt only, pin passes through
        tvs[0] = CMP + 3; tick(1);
        wr(1'b0, 16'hA);
        clr_flag();
        gpio_in = 1'b1; tick(1);
        check("R8 pin follows gpio high", pin_out, 1);
        gpio_in = 1'b0; tick(1);
        check("R8 pin follows gpio low", pin_out, 0);
        tvs[0] = CMP; tick(1);
        check("R8 flag on match", flag, 1);
        check("R8 pin still gpio", pin_out, 0);
        gpio_in = 1'b1; #1;
        check("R8 pin still gpio after match", pin_out, 1);
        gpio_in = 1'b0;

        // R9: special event
        tvs[0] = CMP + 3; tick(1);
        wr(1'b0, 16'hB);
        clr_flag();
        pin_before = pin_out;
        t0 = trig_cnt;
        tvs[0] = CMP; tick(3);
        check("R9 one reset pulse", trig_cnt - t0, 1);
        check("R9 flag set", flag, 1);
        check("R9 pin unchanged", pin_out, pin_before);

        // R11: sticky and set-wins
        tick(4);
        check("R11 flag held", flag, 1);
        clr_flag();
        check("R11 flag cleared", flag, 0);
        tvs[0] = CMP + 3; tick(1);
        tvs[0] = CMP; flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check("R11 set wins over clear", flag, 1);

        // R10: disabled codes
        for (int k = 0; k < 7; k++) begin
            tvs[0] = CMP + 3; tick(1);
            wr(1'b0, {12'h0, off_codes[k]});
            clr_flag();
            exp_cap = cap_val;
            t0 = trig_cnt;
            tvs[0] = CMP;
            pulse();
            check("R10 no flag", flag, 0);
            check("R10 no capture", cap_val, exp_cap);
            check("R10 pin low", pin_out, 0);
            check("R10 no reset pulse", trig_cnt - t0, 0);
        end
        // R10: disabling clears the prescaler
        tvs[0] = 16'h2468;
        wr(1'b0, 16'h6);
        pulse(); pulse(); pulse();
        wr(1'b0, 16'h0);
        tick(2);
        exp_cap = cap_val;
        wr(1'b0, 16'h6);
        pulse();
        check("R10 prescaler cleared when off", cap_val, exp_cap);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule